// File: doc/BRIEF.md
# Receive Byte Order Realignment

This block follows a 1:2 receive byte deserializer in an OC-48 style SONET/SDH path. Each input word carries two bytes. Within a word, the high byte `in_data[15:8]` is the earlier byte in time and the low byte `in_data[7:0]` is the later one. After deserialization, the word boundary may be off by one byte. When that happens, a word's high byte ends up paired with the low byte of the next word.

The block watches the word-alignment sync flag. On each low-to-high transition of that flag, it compares the low byte with the configured second framing byte (`A2_BYTE`, default 0x28). If the two differ, it inserts one pad byte (`PAD_BYTE`, default equal to the first framing byte `A1_BYTE`, 0xF6). From then on it carries one byte over between cycles, so that later output words are paired correctly. A status output reports that ordering has been settled. When the sync flag drops, the block clears the status and returns to plain pass-through.

Top module: `rx_byte_realign`

## Requirements
- R1: When no shift is active, a valid input word appears unchanged on `out_data` one clock later, and `out_valid` equals `in_valid` delayed by one clock.
- R2: Only a low-to-high transition of `in_sync` starts a comparison of `in_data[7:0]` against `A2_BYTE`. While `in_sync` stays high, no new comparison is made, even if the low byte differs from `A2_BYTE`.
- R3: On a comparison that mismatches, the output word one clock later is `{in_data[15:8], PAD_BYTE}`, and `in_data[7:0]` is held back for the next word.
- R4: After a pad, each valid input produces the output `{held byte, in_data[15:8]}` one clock later, and `in_data[7:0]` becomes the new held byte.
- R5: On a comparison that matches, no pad is inserted and the data keeps passing through unchanged.
- R6: `order_locked` rises one clock after the comparison cycle, whether or not a pad was inserted. It stays high while `in_sync` stays high.
- R7: A cycle with `in_sync` low clears `order_locked` one clock later and cancels any shift. The word from that cycle passes through unchanged.
- R8: On a cycle with `in_valid` low, `out_valid` is 0 one clock later, `out_data` keeps its previous value, and the held byte is kept.
- R9: If the transition of `in_sync` occurs on a cycle with `in_valid` low, the comparison is made on the next valid cycle in which `in_sync` is still high.
- R10: Synchronous active-high reset drives `out_valid`, `out_data` and `order_locked` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | 16 | Input word, [15:8] earlier byte |
| in_sync | input | 1 | Word-alignment sync flag |
| out_valid | output | 1 | Output word qualifier |
| out_data | output | 16 | Reordered output word |
| order_locked | output | 1 | Byte ordering settled |

## Verification
Every output is one register away from the inputs. Data, valid and status for an input driven in cycle N are therefore all due after the clock edge that closes cycle N. The bench applies each vector at a falling edge and compares the outputs at the next falling edge. Cases that depend on history are listed as consecutive vectors, so the expected value always refers to the cycle just before. These cases are the held byte after a pad, a deferred comparison, and the fall of the status.

// File: rtl/rx_realign_pkg.sv
package rx_realign_pkg;
    typedef enum logic [1:0] {
        M_PASS  = 2'd0,
        M_PAD   = 2'd1,
        M_SHIFT = 2'd2
    } merge_mode_e;
endpackage

// File: rtl/rx_sync_edge.sv
module rx_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic sync_i,
    output logic rise_o
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rise_o = sync_i & ~st_q.prev;

    // R2
    no_double_rise_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/rx_order_decide.sv
module rx_order_decide
    import rx_realign_pkg::*;
#(
    parameter int          BYTE_W  = 8,
    parameter logic [7:0]  A2_BYTE = 8'h28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic              sync_i,
    input  logic              rise_i,
    input  logic [BYTE_W-1:0] lo_i,
    output merge_mode_e       mode_o,
    output logic              locked_o
);
    typedef struct packed {
        logic pend;
        logic shift;
        logic locked;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic    armed;
    logic    decide_now;
    logic    mism;

    always_comb begin
        armed      = rise_i | st_q.pend;
        decide_now = valid_i & sync_i & armed;
        mism       = (lo_i != A2_BYTE[BYTE_W-1:0]);
        st_d.pend   = sync_i & armed & ~valid_i;
        st_d.shift  = sync_i & (st_q.shift | (decide_now & mism));
        st_d.locked = sync_i & (st_q.locked | decide_now);
        if (!sync_i)                mode_o = M_PASS;
        else if (decide_now & mism) mode_o = M_PAD;
        else if (st_q.shift)        mode_o = M_SHIFT;
        else                        mode_o = M_PASS;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign locked_o = st_q.locked;

    // R7
    lock_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !sync_i |=> !locked_o);
    // R6
    lock_set_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && sync_i && rise_i) |=> locked_o);
    // R3
    pad_then_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == M_PAD) |=> st_q.shift);
endmodule

// File: rtl/rx_byte_merge.sv
module rx_byte_merge
    import rx_realign_pkg::*;
#(
    parameter int         BYTE_W   = 8,
    parameter logic [7:0] PAD_BYTE = 8'hF6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                valid_i,
    input  logic [2*BYTE_W-1:0] data_i,
    input  merge_mode_e         mode_i,
    output logic                valid_o,
    output logic [2*BYTE_W-1:0] data_o
);
    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
        logic [BYTE_W-1:0] held;
    } mrg_st_t;

    mrg_st_t           st_d, st_q;
    logic [BYTE_W-1:0] hi_b, lo_b;

    always_comb begin
        hi_b     = data_i[WORD_W-1:BYTE_W];
        lo_b     = data_i[BYTE_W-1:0];
        st_d     = st_q;
        st_d.vld = valid_i;
        if (valid_i) begin
            unique case (mode_i)
                M_PAD: begin
                    st_d.word = {hi_b, PAD_BYTE[BYTE_W-1:0]};
                    st_d.held = lo_b;
                end
                M_SHIFT: begin
                    st_d.word = {st_q.held, hi_b};
                    st_d.held = lo_b;
                end
                default: st_d.word = data_i;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign valid_o = st_q.vld;
    assign data_o  = st_q.word;

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!valid_o && $stable(data_o)));
endmodule

// File: rtl/rx_byte_realign.sv
module rx_byte_realign
    import rx_realign_pkg::*;
#(
    parameter int         BYTE_W   = 8,
    parameter logic [7:0] A1_BYTE  = 8'hF6,
    parameter logic [7:0] A2_BYTE  = 8'h28,
    parameter logic [7:0] PAD_BYTE = A1_BYTE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [2*BYTE_W-1:0] in_data,
    input  logic                in_sync,
    output logic                out_valid,
    output logic [2*BYTE_W-1:0] out_data,
    output logic                order_locked
);
    logic        sync_rise;
    merge_mode_e mode;

    rx_sync_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sync_i (in_sync),
        .rise_o (sync_rise)
    );

    rx_order_decide #(
        .BYTE_W  (BYTE_W),
        .A2_BYTE (A2_BYTE)
    ) u_decide (
        .clk      (clk),
        .rst      (rst),
        .valid_i  (in_valid),
        .sync_i   (in_sync),
        .rise_i   (sync_rise),
        .lo_i     (in_data[BYTE_W-1:0]),
        .mode_o   (mode),
        .locked_o (order_locked)
    );

    rx_byte_merge #(
        .BYTE_W   (BYTE_W),
        .PAD_BYTE (PAD_BYTE)
    ) u_merge (
        .clk     (clk),
        .rst     (rst),
        .valid_i (in_valid),
        .data_i  (in_data),
        .mode_i  (mode),
        .valid_o (out_valid),
        .data_o  (out_data)
    );
endmodule

// File: tb/rx_byte_realign_tb.sv
module rx_byte_realign_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_sync = 1'b0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        order_locked;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    rx_byte_realign dut_i (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_sync      (in_sync),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .order_locked (order_locked)
    );

    // {valid, sync, data, exp_valid, exp_data, exp_locked}
    localparam int NV = 15;
    localparam logic [35:0] VEC [NV] = '{
        {1'b1, 1'b0, 16'h1234, 1'b1, 16'h1234, 1'b0}, // R1 pass
        {1'b1, 1'b1, 16'hF6F6, 1'b1, 16'hF6F6, 1'b1}, // R3 pad on mismatch
        {1'b1, 1'b1, 16'h2828, 1'b1, 16'hF628, 1'b1}, // R4 shifted
        {1'b1, 1'b1, 16'hAABB, 1'b1, 16'h28AA, 1'b1}, // R4
        {1'b0, 1'b1, 16'hCCDD, 1'b0, 16'h28AA, 1'b1}, // R8 idle hold
        {1'b1, 1'b1, 16'h1122, 1'b1, 16'hBB11, 1'b1}, // R8 held byte kept
        {1'b1, 1'b0, 16'h3344, 1'b1, 16'h3344, 1'b0}, // R7 fall
        {1'b1, 1'b1, 16'h5528, 1'b1, 16'h5528, 1'b1}, // R5 match
        {1'b1, 1'b1, 16'h6677, 1'b1, 16'h6677, 1'b1}, // R5 no shift
        {1'b1, 1'b1, 16'h99F6, 1'b1, 16'h99F6, 1'b1}, // R2 level no recheck
        {1'b1, 1'b0, 16'h0102, 1'b1, 16'h0102, 1'b0}, // R7
        {1'b0, 1'b1, 16'hF6F6, 1'b0, 16'h0102, 1'b0}, // R9 rise while idle
        {1'b1, 1'b1, 16'hF6F6, 1'b1, 16'hF6F6, 1'b1}, // R9 deferred pad
        {1'b1, 1'b1, 16'hA1B2, 1'b1, 16'hF6A1, 1'b1}, // R6 lock stays
        {1'b1, 1'b0, 16'hC3D4, 1'b1, 16'hC3D4, 1'b0}  // R7
    };

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic v, input logic s, input logic [15:0] d);
        in_valid = v;
        in_sync  = s;
        in_data  = d;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 valid", {15'd0, out_valid}, 16'd0);
        check("R10 data", out_data, 16'd0);
        check("R10 locked", {15'd0, order_locked}, 16'd0);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][35], VEC[i][34], VEC[i][33:18]);
            check($sformatf("vec%0d valid R1", i), {15'd0, out_valid}, {15'd0, VEC[i][17]});
            check($sformatf("vec%0d data", i), out_data, VEC[i][16:1]);
            check($sformatf("vec%0d locked R6", i), {15'd0, order_locked}, {15'd0, VEC[i][0]});
        end
        // R3 pad then R10 reset while shifted
        drive(1'b1, 1'b1, 16'h00F6);
        check("R3 pad word", out_data, 16'h00F6);
        drive(1'b1, 1'b1, 16'h5A5A);
        check("R4 shift word", out_data, 16'hF65A);
        rst = 1'b1;
        drive(1'b1, 1'b1, 16'h1111);
        check("R10 reset data", out_data, 16'd0);
        check("R10 reset locked", {15'd0, order_locked}, 16'd0);
        check("R10 reset valid", {15'd0, out_valid}, 16'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule